// File: doc/BRIEF.md
# Banked Display Memory with Data Pointer

This block is the display data store of a dot-matrix panel controller, together with the address pointer that the host uses to walk through it. The store has two banks of equal depth. A one-bit bank flag picks the bank, and a word counter picks the word inside it. Every host access works on the word under the pointer. That access is a byte write, a byte read, or forcing a single bit to one or zero. After the access the pointer moves forward by one, moves back by one, or stays, so a run of bytes can be streamed into or out of one bank without reloading the address.

The host sends one command per cycle on a small command port. A command has a 3-bit opcode and a 7-bit argument, plus a data byte that only writes use. For byte accesses, the step direction comes from a stored movement mode. A bit command carries its own direction field and ignores the stored mode. A stop command puts the stored mode back to forward stepping. Reset clears the pointer and the mode but leaves the stored bytes alone, so the panel image survives a reset or a standby exit.

Top module: `dptr_top`

## Requirements
- R1: With `rst_n` low, the pointer is word 0 of bank 0, the mode is forward, and `rd_valid` is 0; the stored bytes keep their values through reset.
- R2: LOAD (opcode 1) sets the word counter to `cmd_arg[5:0]` and the bank flag to `cmd_arg[6]` when the word value is below WORDS; otherwise the pointer is unchanged.
- R3: MODE (opcode 2) takes `cmd_arg[1:0]` as the movement mode: 0 forward, 1 backward, 2 hold; the value 3 is ignored and the previous mode stays in force.
- R4: WRITE (opcode 3) stores `wr_data` in the addressed word of the selected bank, and the pointer then moves by the stored mode.
- R5: READ (opcode 4) returns the addressed byte on `rd_data`, with `rd_valid` high for exactly the cycle after the command; the pointer then moves by the stored mode.
- R6: Stepping forward from word WORDS-1 gives word 0, stepping backward from word 0 gives word WORDS-1, and the bank flag never changes on a step.
- R7: BSET (opcode 5) and BCLR (opcode 6) force bit `cmd_arg[2:0]` of the addressed byte to 1 or 0 and leave the other bits alone, in every mode, without changing the stored mode.
- R8: After BSET or BCLR the pointer moves by `cmd_arg[4:3]`: 0 forward, 1 backward, 2 or 3 hold. The stored mode is not used for this step.
- R9: STOP (opcode 7) sets the mode to forward and changes neither the pointer nor the stored bytes.
- R10: The two banks are separate storage: a write at one word index in one bank does not change the same index in the other bank.
- R11: NOP (opcode 0), or any cycle with `cmd_valid` low, changes neither the pointer, the mode nor the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_arg | input | 7 | Command argument |
| wr_data | input | WIDTH | Byte to store on WRITE |
| rd_valid | output | 1 | `rd_data` holds a fresh read result |
| rd_data | output | WIDTH | Byte returned by the last READ |
| ptr_word | output | PTR_W | Current word counter |
| ptr_bank | output | 1 | Current bank flag |

## Verification
The bench uses the default build: 50 words per bank and 8-bit words. This puts both wrap boundaries (49 and 0) and the smallest out-of-range load values (50 to 63, which fit in the 6-bit field) within reach of directed tests. With only 100 cells in total, the bench can fill both banks in full before the random phase. From then on every random read has a known expected byte, and a reset in the middle of the run can be checked against the whole image.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_MODE  = 3'd2,
        OP_WRITE = 3'd3,
        OP_READ  = 3'd4,
        OP_BSET  = 3'd5,
        OP_BCLR  = 3'd6,
        OP_STOP  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        MV_INC  = 2'd0,
        MV_DEC  = 2'd1,
        MV_HOLD = 2'd2,
        MV_BAD  = 2'd3
    } move_e;

endpackage

// File: rtl/dptr_step.sv
module dptr_step
    import dptr_pkg::*;
#(
    parameter int WORDS = 50,
    parameter int PTR_W = 6
) (
    input  logic [PTR_W-1:0] cur,
    input  move_e            dir,
    output logic [PTR_W-1:0] nxt
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(WORDS - 1);

    // The counter wraps inside one bank; the bank flag is handled elsewhere.
    always_comb begin
        case (dir)
            MV_INC:  nxt = (cur == LAST) ? '0 : cur + PTR_W'(1);
            MV_DEC:  nxt = (cur == '0) ? LAST : cur - PTR_W'(1);
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/dptr_decode.sv
module dptr_decode
    import dptr_pkg::*;
#(
    parameter int WORDS = 50,
    parameter int PTR_W = 6,
    parameter int BIT_W = 3
) (
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [6:0]       cmd_arg,
    input  move_e            mode_q,
    output logic             load_ok,
    output logic             mode_ok,
    output logic             stop_req,
    output logic             wr_req,
    output logic             rd_req,
    output logic             bit_req,
    output logic             bit_val,
    output logic             advance,
    output move_e            dir,
    output logic [PTR_W-1:0] load_word,
    output logic             load_bank,
    output move_e            mode_val,
    output logic [BIT_W-1:0] bit_idx
);
    op_e op;

    assign op        = op_e'(cmd_op);
    assign load_word = cmd_arg[PTR_W-1:0];
    assign load_bank = cmd_arg[6];
    assign mode_val  = move_e'(cmd_arg[1:0]);
    assign bit_idx   = cmd_arg[BIT_W-1:0];

    always_comb begin
        load_ok  = 1'b0;
        mode_ok  = 1'b0;
        stop_req = 1'b0;
        wr_req   = 1'b0;
        rd_req   = 1'b0;
        bit_req  = 1'b0;
        bit_val  = 1'b0;
        advance  = 1'b0;
        dir      = mode_q;
        if (cmd_valid) begin
            case (op)
                OP_LOAD:  load_ok  = 32'(cmd_arg[PTR_W-1:0]) < WORDS;
                OP_MODE:  mode_ok  = (mode_val != MV_BAD);
                OP_STOP:  stop_req = 1'b1;
                OP_WRITE: begin
                    wr_req  = 1'b1;
                    advance = 1'b1;
                end
                OP_READ: begin
                    rd_req  = 1'b1;
                    advance = 1'b1;
                end
                OP_BSET, OP_BCLR: begin
                    bit_req = 1'b1;
                    bit_val = (op == OP_BSET);
                    advance = 1'b1;
                    dir     = move_e'(cmd_arg[4:3]);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dptr_store.sv
module dptr_store #(
    parameter int WORDS = 50,
    parameter int WIDTH = 8,
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             addr_bank,
    input  logic [PTR_W-1:0] addr_word,
    input  logic [WIDTH-1:0] wr_val,
    output logic [WIDTH-1:0] cur_val
);
    localparam int BANKS = 2;

    logic [WIDTH-1:0] bank_out [BANKS];

    // Storage has no reset, so its contents outlive a reset of the pointer.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [WIDTH-1:0] cells [WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && (addr_bank == 1'(b))) begin
                cells[addr_word] <= wr_val;
            end
        end

        assign bank_out[b] = cells[addr_word];
    end

    assign cur_val = bank_out[addr_bank];
endmodule

// File: rtl/dptr_top.sv
module dptr_top
    import dptr_pkg::*;
#(
    parameter int WORDS = 50,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(WORDS),
    localparam int BIT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [6:0]       cmd_arg,
    input  logic [WIDTH-1:0] wr_data,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic [PTR_W-1:0] ptr_word,
    output logic             ptr_bank
);
    typedef struct packed {
        logic [PTR_W-1:0] word;
        logic             bank;
        move_e            mode;
        logic             rd_valid;
        logic [WIDTH-1:0] rd_data;
    } state_t;

    state_t state_q, state_d;

    logic             load_ok, mode_ok, stop_req, wr_req, rd_req;
    logic             bit_req, bit_val, advance;
    move_e            dir, mode_val;
    logic [PTR_W-1:0] load_word, step_word;
    logic             load_bank;
    logic [BIT_W-1:0] bit_idx;
    logic [WIDTH-1:0] cur_val, wr_val, bit_mask;
    logic             wr_en;

    dptr_decode #(.WORDS(WORDS), .PTR_W(PTR_W), .BIT_W(BIT_W)) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .mode_q    (state_q.mode),
        .load_ok   (load_ok),
        .mode_ok   (mode_ok),
        .stop_req  (stop_req),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .bit_req   (bit_req),
        .bit_val   (bit_val),
        .advance   (advance),
        .dir       (dir),
        .load_word (load_word),
        .load_bank (load_bank),
        .mode_val  (mode_val),
        .bit_idx   (bit_idx)
    );

    dptr_step #(.WORDS(WORDS), .PTR_W(PTR_W)) u_step (
        .cur (state_q.word),
        .dir (dir),
        .nxt (step_word)
    );

    dptr_store #(.WORDS(WORDS), .WIDTH(WIDTH), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .addr_bank (state_q.bank),
        .addr_word (state_q.word),
        .wr_val    (wr_val),
        .cur_val   (cur_val)
    );

    // Bit commands are a read-modify-write of the addressed word in one cycle.
    always_comb begin
        bit_mask = WIDTH'(1) << bit_idx;
        wr_en    = wr_req | bit_req;
        if (wr_req) begin
            wr_val = wr_data;
        end else if (bit_val) begin
            wr_val = cur_val | bit_mask;
        end else begin
            wr_val = cur_val & ~bit_mask;
        end
    end

    always_comb begin
        state_d          = state_q;
        state_d.rd_valid = rd_req;
        if (rd_req) begin
            state_d.rd_data = cur_val;
        end
        if (load_ok) begin
            state_d.word = load_word;
            state_d.bank = load_bank;
        end
        if (advance) begin
            state_d.word = step_word;
        end
        if (mode_ok) begin
            state_d.mode = mode_val;
        end
        if (stop_req) begin
            state_d.mode = MV_INC;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.word     <= '0;
            state_q.bank     <= 1'b0;
            state_q.mode     <= MV_INC;
            state_q.rd_valid <= 1'b0;
            state_q.rd_data  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_valid = state_q.rd_valid;
    assign rd_data  = state_q.rd_data;
    assign ptr_word = state_q.word;
    assign ptr_bank = state_q.bank;
endmodule

// File: rtl/dptr_chk.sv
module dptr_chk
    import dptr_pkg::*;
#(
    parameter int WORDS = 50,
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [6:0]       cmd_arg,
    input logic             rd_valid,
    input logic [PTR_W-1:0] ptr_word,
    input logic             ptr_bank,
    input move_e            mode
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(WORDS - 1);

    logic byte_op;
    assign byte_op = cmd_valid && (cmd_op == OP_WRITE || cmd_op == OP_READ);

    // R2
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_LOAD && 32'(cmd_arg[PTR_W-1:0]) < WORDS)
        |=> (ptr_word == $past(cmd_arg[PTR_W-1:0]) && ptr_bank == $past(cmd_arg[6])));

    // R2
    load_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_LOAD && 32'(cmd_arg[PTR_W-1:0]) >= WORDS)
        |=> ($stable(ptr_word) && $stable(ptr_bank)));

    // R3
    bad_mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_MODE && cmd_arg[1:0] == 2'd3) |=> $stable(mode));

    // R5
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_READ) |=> rd_valid);

    // R5
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == OP_READ) |=> !rd_valid);

    // R6
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_op && mode == MV_INC && ptr_word == LAST)
        |=> (ptr_word == '0 && $stable(ptr_bank)));

    // R6
    dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_op && mode == MV_DEC && ptr_word == '0)
        |=> (ptr_word == LAST && $stable(ptr_bank)));

    // R6
    word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ptr_word) < WORDS);

    // R7
    bit_mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_BSET || cmd_op == OP_BCLR)) |=> $stable(mode));

    // R9
    stop_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_STOP)
        |=> (mode == MV_INC && $stable(ptr_word) && $stable(ptr_bank)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || cmd_op == OP_NOP)
        |=> ($stable(ptr_word) && $stable(ptr_bank) && $stable(mode)));
endmodule

bind dptr_top dptr_chk #(.WORDS(WORDS), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_arg   (cmd_arg),
    .rd_valid  (rd_valid),
    .ptr_word  (ptr_word),
    .ptr_bank  (ptr_bank),
    .mode      (state_q.mode)
);

// File: tb/test_dptr_top.sv
module test_dptr_top;
    localparam int WORDS = 50;
    localparam int WIDTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [6:0] cmd_arg = '0;
    logic [7:0] wr_data = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [5:0] ptr_word;
    logic       ptr_bank;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem_m [2][WORDS];
    int m_word = 0;
    int m_bank = 0;
    int m_mode = 0;

    always #10 clk = ~clk;

    dptr_top #(.WORDS(WORDS), .WIDTH(WIDTH)) i_dptr_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .wr_data   (wr_data),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .ptr_word  (ptr_word),
        .ptr_bank  (ptr_bank)
    );

    function automatic int step(int w, int dir);
        if (dir == 0) return (w == WORDS - 1) ? 0 : w + 1;
        if (dir == 1) return (w == 0) ? WORDS - 1 : w - 1;
        return w;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    task automatic run_cmd(input bit v, input int op, input int arg, input int wd, input string tag);
        int  exp_rd = 0;
        bit  is_rd = v && (op == 4);
        if (v) begin
            case (op)
                1: if ((arg & 63) < WORDS) begin
                    m_word = arg & 63;
                    m_bank = (arg >> 6) & 1;
                end
                2: if ((arg & 3) != 3) m_mode = arg & 3;
                3: begin
                    mem_m[m_bank][m_word] = 8'(wd);
                    m_word = step(m_word, m_mode);
                end
                4: begin
                    exp_rd = int'(mem_m[m_bank][m_word]);
                    m_word = step(m_word, m_mode);
                end
                5, 6: begin
                    mem_m[m_bank][m_word][arg & 7] = (op == 5);
                    m_word = step(m_word, (arg >> 3) & 3);
                end
                7: m_mode = 0;
                default: ;
            endcase
        end
        cmd_valid = v;
        cmd_op    = 3'(op);
        cmd_arg   = 7'(arg);
        wr_data   = 8'(wd);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(int'(ptr_word) == m_word, tag, int'(ptr_word), m_word);
        check(int'(ptr_bank) == m_bank, tag, int'(ptr_bank), m_bank);
        check(rd_valid == is_rd, tag, int'(rd_valid), int'(is_rd));
        if (is_rd) check(int'(rd_data) == exp_rd, tag, int'(rd_data), exp_rd);
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
        m_word = 0;
        m_bank = 0;
        m_mode = 0;
        // R1: pointer and read flag after reset
        check(ptr_word == 6'd0, "R1", int'(ptr_word), 0);
        check(ptr_bank == 1'b0, "R1", int'(ptr_bank), 0);
        check(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
    endtask

    initial begin
        #(20 * 200000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        string tags [8] = '{"R11", "R2", "R3", "R4", "R5", "R7", "R8", "R9"};
        void'($urandom(32'd2024));
        do_reset();

        // R4 R6: fill both banks with forward writes, wrapping back to word 0
        run_cmd(1, 1, 7'h00, 0, "R2");
        for (int i = 0; i < WORDS; i++) run_cmd(1, 3, 0, int'($urandom_range(255, 0)), "R4");
        check(ptr_word == 6'd0, "R6", int'(ptr_word), 0);
        run_cmd(1, 1, 7'h40, 0, "R2");
        for (int i = 0; i < WORDS; i++) run_cmd(1, 3, 0, int'($urandom_range(255, 0)), "R6");

        // R6: backward wrap from word 0 to the last word, bank kept
        run_cmd(1, 2, 1, 0, "R3");
        run_cmd(1, 1, 7'h40, 0, "R2");
        run_cmd(1, 4, 0, 0, "R6");
        check(ptr_word == 6'(WORDS - 1), "R6", int'(ptr_word), WORDS - 1);

        // R3: reserved mode value keeps backward stepping
        run_cmd(1, 2, 3, 0, "R3");
        run_cmd(1, 4, 0, 0, "R3");

        // R5: hold mode reads the same word twice
        run_cmd(1, 2, 2, 0, "R3");
        run_cmd(1, 4, 0, 0, "R5");
        run_cmd(1, 4, 0, 0, "R5");

        // R2: out-of-range loads are dropped
        run_cmd(1, 1, 7'h3F, 0, "R2");
        run_cmd(1, 1, 7'h72, 0, "R2");

        // R7 R8: bit commands in hold mode use their own step field
        run_cmd(1, 1, 7'h0A, 0, "R2");
        run_cmd(1, 5, 7'h05, 0, "R8");
        run_cmd(1, 6, 7'h0D, 0, "R8");
        run_cmd(1, 6, 7'h18, 0, "R8");
        run_cmd(1, 5, 7'h17, 0, "R8");
        run_cmd(1, 1, 7'h0A, 0, "R2");
        run_cmd(1, 4, 0, 0, "R7");
        run_cmd(1, 1, 7'h0B, 0, "R2");
        run_cmd(1, 4, 0, 0, "R7");

        // R10: same index in the two banks holds distinct bytes
        run_cmd(1, 1, 7'h05, 0, "R2");
        run_cmd(1, 3, 0, 8'hAA, "R10");
        run_cmd(1, 1, 7'h45, 0, "R2");
        run_cmd(1, 3, 0, 8'h55, "R10");
        run_cmd(1, 1, 7'h05, 0, "R2");
        run_cmd(1, 4, 0, 0, "R10");
        check(rd_data == 8'hAA, "R10", int'(rd_data), 8'hAA);

        // R9: stop returns to forward stepping
        run_cmd(1, 7, 0, 0, "R9");
        run_cmd(1, 4, 0, 0, "R9");

        // R11: idle cycles with junk on the bus and a NOP change nothing
        run_cmd(0, 3, 0, 8'h12, "R11");
        run_cmd(0, 1, 7'h20, 0, "R11");
        run_cmd(1, 0, 7'h20, 0, "R11");
        run_cmd(1, 4, 0, 0, "R11");

        // R1: contents survive a reset mid-run
        do_reset();
        for (int i = 0; i < WORDS; i++) run_cmd(1, 4, 0, 0, "R1");
        run_cmd(1, 1, 7'h40, 0, "R2");
        for (int i = 0; i < WORDS; i++) run_cmd(1, 4, 0, 0, "R1");

        // Random phase over all commands
        for (int i = 0; i < 800; i++) begin
            int op  = int'($urandom_range(7, 0));
            int arg = int'($urandom_range(127, 0));
            bit v   = ($urandom_range(9, 0) != 0);
            if (op == 2 && $urandom_range(3, 0) == 0) arg = 3;
            if (op == 7 && $urandom_range(1, 0) == 0) op = 4;
            run_cmd(v, op, arg, int'($urandom_range(255, 0)), v ? tags[op] : "R11");
        end

        finish_run();
    end
endmodule